// File: doc/BRIEF.md
# Break-Protected Two-Step Status Flag

This block holds a small set of peripheral status flags. Each flag is set by a one-cycle hardware event pulse. Software clears a flag in two steps. The first step is a read of the status register while the flag is 1, which arms a per-flag pending bit. The second step is a read or write of the data register, which clears every armed flag. Each flag raises its interrupt output when the matching enable bit is 1.

A debug-halt input (`brk_i`) works together with a clear-enable control bit. When the system is halted and clear-enable is 0, no clearing step has any effect: a debugger can read and write every register without losing a status bit. A pending bit armed before the halt stays armed through it, so the second step completes the clear once the halt is released. When clear-enable is 1, clearing works during the halt as it does normally. A flag cleared that way stays cleared after the halt ends.

Register map, selected by the 2-bit `acc_addr`:
- Status (0): read-only.
- Control (1): bit 0 is clear-enable.
- Interrupt enable (2): one bit per flag.
- Data (3): read/write.

Read data is combinational from the address.

Top module: `brk_flag_unit`

## Requirements
- R1: After reset, all flags, pending bits, interrupt enables and clear-enable are 0, so `flag_o` and `irq_o` are 0.
- R2: An `evt_i[i]` pulse makes `flag_o[i]` 1 at the next clock edge. A flag never becomes 1 without an event.
- R3: A read of address 0 while a flag is 1, followed later by a read or write of address 3, makes that flag 0 at the edge of the second access. An address-3 access with no prior arming leaves the flags unchanged.
- R4: While `brk_i` is 1 and clear-enable (address 1, bit 0) is 0, no flag is cleared. Register accesses neither arm nor disarm pending bits.
- R5: A flag armed before the halt stays 1 through address-3 accesses made during the halt. The first address-3 access after `brk_i` returns to 0 clears it.
- R6: With clear-enable 1, the two-step clear works during the halt, and the flag stays 0 after the halt ends.
- R7: An event in the same cycle as the second step keeps that flag 1 and drops its pending bit, so a later address-3 access does not clear it. Other armed flags still clear.
- R8: `irq_o[i]` is 1 exactly when `flag_o[i]` is 1 and bit i of the interrupt-enable register (address 2) is 1.
- R9: `acc_rdata` shows, with zero extension where needed:
  - address 0: the flags;
  - address 1: clear-enable in bit 0;
  - address 2: the interrupt enables;
  - address 3: the last value written to the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| evt_i | input | NFLAG | Per-flag hardware set pulses |
| brk_i | input | 1 | System halted for debug |
| acc_rd | input | 1 | Register read strobe |
| acc_wr | input | 1 | Register write strobe |
| acc_addr | input | 2 | Register select |
| acc_wdata | input | DW | Write data |
| acc_rdata | output | DW | Read data for `acc_addr` |
| flag_o | output | NFLAG | Flag state |
| irq_o | output | NFLAG | Enabled flag interrupts |

## Verification
A hardware set event and the second clearing step can fall on the same clock edge. The bench provokes this in two ways:
- It drives `evt_i` during an address-3 read on an armed flag.
- It drives an event on one armed flag while another armed flag clears.

The scoreboard expects the colliding flag to stay 1 and to survive a further address-3 access, while the other flag drops. An assertion checks on every edge that a pulsed flag is 1 afterwards.

// File: rtl/brk_flag_unit.sv
module brk_flag_unit #(
  parameter int NFLAG = 4,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] evt_i,
  input  logic             brk_i,
  input  logic             acc_rd,
  input  logic             acc_wr,
  input  logic [1:0]       acc_addr,
  input  logic [DW-1:0]    acc_wdata,
  output logic [DW-1:0]    acc_rdata,
  output logic [NFLAG-1:0] flag_o,
  output logic [NFLAG-1:0] irq_o
);
  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_IEN  = 2'd2;
  localparam logic [1:0] A_DATA = 2'd3;
  localparam logic [NFLAG-1:0] NONE = {NFLAG{1'b0}};

  logic [NFLAG-1:0] flag_q, pend_q, ien_q;
  logic             clr_en_q;
  logic [DW-1:0]    data_q;

  wire hold  = brk_i & ~clr_en_q;
  wire step1 = acc_rd & (acc_addr == A_STAT) & ~hold;
  wire step2 = (acc_rd | acc_wr) & (acc_addr == A_DATA) & ~hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q   <= NONE;
      pend_q   <= NONE;
      ien_q    <= NONE;
      clr_en_q <= 1'b0;
      data_q   <= '0;
    end else begin
      flag_q <= (flag_q & ~(step2 ? pend_q : NONE)) | evt_i;
      pend_q <= (step2 ? NONE : (step1 ? (pend_q | flag_q) : pend_q)) & ~evt_i;
      if (acc_wr && acc_addr == A_CTRL) clr_en_q <= acc_wdata[0];
      if (acc_wr && acc_addr == A_IEN)  ien_q    <= acc_wdata[NFLAG-1:0];
      if (acc_wr && acc_addr == A_DATA) data_q   <= acc_wdata;
    end
  end

  always_comb begin
    acc_rdata = '0;
    case (acc_addr)
      A_STAT:  acc_rdata[NFLAG-1:0] = flag_q;
      A_CTRL:  acc_rdata[0]         = clr_en_q;
      A_IEN:   acc_rdata[NFLAG-1:0] = ien_q;
      default: acc_rdata            = data_q;
    endcase
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & ien_q;
endmodule

module brk_flag_unit_chk #(
  parameter int NFLAG = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NFLAG-1:0] evt_i,
  input logic             brk_i,
  input logic             acc_rd,
  input logic             acc_wr,
  input logic [1:0]       acc_addr,
  input logic             clr_en,
  input logic [NFLAG-1:0] flag_o
);
  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((flag_o & $past(evt_i)) == $past(evt_i)));

  assert_no_spurious_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i == '0) |=> ((flag_o & ~$past(flag_o)) == '0));

  assert_clear_needs_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !((acc_rd || acc_wr) && acc_addr == 2'd3) |=> ((flag_o & $past(flag_o)) == $past(flag_o)));

  assert_halt_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_i && !clr_en) |=> ((flag_o & $past(flag_o)) == $past(flag_o)));
endmodule

bind brk_flag_unit brk_flag_unit_chk #(.NFLAG(NFLAG)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .brk_i(brk_i),
  .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_addr(acc_addr),
  .clr_en(clr_en_q), .flag_o(flag_o)
);

// File: tb/sim_brk_flag_unit.sv
module sim_brk_flag_unit;
  localparam int NFLAG = 4;
  localparam int DW    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NFLAG-1:0] evt_i = '0;
  logic brk_i = 1'b0, acc_rd = 1'b0, acc_wr = 1'b0;
  logic [1:0] acc_addr = '0;
  logic [DW-1:0] acc_wdata = '0;
  logic [DW-1:0] acc_rdata;
  logic [NFLAG-1:0] flag_o, irq_o;

  always #2 clk = ~clk;

  brk_flag_unit #(.NFLAG(NFLAG), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .brk_i(brk_i),
    .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .flag_o(flag_o), .irq_o(irq_o));

  typedef struct {
    logic [NFLAG-1:0] f;
    logic [NFLAG-1:0] i;
    string            tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (flag_o !== e.f || irq_o !== e.i) begin
        errors++;
        $display("FAIL %s: flag=%b irq=%b expected flag=%b irq=%b",
                 e.tag, flag_o, irq_o, e.f, e.i);
      end
    end
  end

  task automatic cyc(input logic rd, input logic wr, input logic [1:0] a,
                     input logic [DW-1:0] wd, input logic [NFLAG-1:0] ev,
                     input logic [NFLAG-1:0] ef, input logic [NFLAG-1:0] ei,
                     input string tag);
    exp_t e;
    @(negedge clk);
    acc_rd = rd; acc_wr = wr; acc_addr = a; acc_wdata = wd; evt_i = ev;
    @(posedge clk);
    #1;
    acc_rd = 1'b0; acc_wr = 1'b0; evt_i = '0;
    e.f = ef; e.i = ei; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic peek(input logic [1:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    acc_addr = a;
    #1;
    checks++;
    if (acc_rdata !== exp) begin
      errors++;
      $display("FAIL %s: rdata=%h expected %h", tag, acc_rdata, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog: run incomplete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc(0, 0, 2'd0, 8'h00, 4'b0000, 4'b0000, 4'b0000, "R1 reset state");
    peek(2'd1, 8'h00, "R1 clear-enable reset");

    // Set and plain two-step clear
    cyc(0, 0, 2'd0, 8'h00, 4'b0001, 4'b0001, 4'b0000, "R2 event sets flag");
    cyc(1, 0, 2'd3, 8'h00, 4'b0000, 4'b0001, 4'b0000, "R3 unarmed data access");
    peek(2'd0, 8'h01, "R9 status read value");
    cyc(1, 0, 2'd0, 8'h00, 4'b0000, 4'b0001, 4'b0000, "R3 arm");
    cyc(0, 1, 2'd3, 8'h11, 4'b0000, 4'b0000, 4'b0000, "R3 data write clears");

    // Armed before halt, held during halt, cleared after
    cyc(0, 0, 2'd0, 8'h00, 4'b0010, 4'b0010, 4'b0000, "R2 set flag1");
    cyc(1, 0, 2'd0, 8'h00, 4'b0000, 4'b0010, 4'b0000, "R5 arm before halt");
    brk_i = 1'b1;
    cyc(1, 0, 2'd3, 8'h00, 4'b0000, 4'b0010, 4'b0000, "R5 data read in halt held");
    cyc(0, 1, 2'd3, 8'h22, 4'b0000, 4'b0010, 4'b0000, "R4 data write in halt held");
    cyc(1, 0, 2'd0, 8'h00, 4'b0000, 4'b0010, 4'b0000, "R4 status read in halt");
    brk_i = 1'b0;
    cyc(0, 0, 2'd0, 8'h00, 4'b0000, 4'b0010, 4'b0000, "R5 after halt still set");
    cyc(1, 0, 2'd3, 8'h00, 4'b0000, 4'b0000, 4'b0000, "R5 second step after halt clears");

    // Arming is ignored during a protected halt
    cyc(0, 0, 2'd0, 8'h00, 4'b0100, 4'b0100, 4'b0000, "R2 set flag2");
    brk_i = 1'b1;
    cyc(1, 0, 2'd0, 8'h00, 4'b0000, 4'b0100, 4'b0000, "R4 status read in halt");
    brk_i = 1'b0;
    cyc(1, 0, 2'd3, 8'h00, 4'b0000, 4'b0100, 4'b0000, "R4 halt read did not arm");
    cyc(1, 0, 2'd0, 8'h00, 4'b0000, 4'b0100, 4'b0000, "R3 arm flag2");
    cyc(1, 0, 2'd3, 8'h00, 4'b0000, 4'b0000, 4'b0000, "R3 clear flag2");

    // Clearing enabled during halt
    cyc(0, 1, 2'd1, 8'h01, 4'b0000, 4'b0000, 4'b0000, "R6 set clear-enable");
    peek(2'd1, 8'h01, "R9 clear-enable readback");
    cyc(0, 0, 2'd0, 8'h00, 4'b1000, 4'b1000, 4'b0000, "R2 set flag3");
    brk_i = 1'b1;
    cyc(1, 0, 2'd0, 8'h00, 4'b0000, 4'b1000, 4'b0000, "R6 arm in halt");
    cyc(1, 0, 2'd3, 8'h00, 4'b0000, 4'b0000, 4'b0000, "R6 clear in halt");
    brk_i = 1'b0;
    cyc(0, 0, 2'd0, 8'h00, 4'b0000, 4'b0000, 4'b0000, "R6 stays clear after halt");

    // Set and clear collisions
    cyc(0, 0, 2'd0, 8'h00, 4'b0001, 4'b0001, 4'b0000, "R2 set flag0");
    cyc(1, 0, 2'd0, 8'h00, 4'b0000, 4'b0001, 4'b0000, "R7 arm flag0");
    cyc(1, 0, 2'd3, 8'h00, 4'b0001, 4'b0001, 4'b0000, "R7 set wins over clear");
    cyc(1, 0, 2'd3, 8'h00, 4'b0000, 4'b0001, 4'b0000, "R7 pending dropped by event");
    cyc(0, 0, 2'd0, 8'h00, 4'b0010, 4'b0011, 4'b0000, "R2 set flag1 too");
    cyc(1, 0, 2'd0, 8'h00, 4'b0000, 4'b0011, 4'b0000, "R7 arm two flags");
    cyc(1, 0, 2'd3, 8'h00, 4'b0010, 4'b0010, 4'b0000, "R7 partial collision");

    // Interrupts and register readback
    cyc(0, 1, 2'd2, 8'h05, 4'b0000, 4'b0010, 4'b0000, "R8 write enables");
    peek(2'd2, 8'h05, "R9 enable readback");
    cyc(0, 0, 2'd0, 8'h00, 4'b1111, 4'b1111, 4'b0101, "R8 masked interrupts");
    cyc(0, 1, 2'd3, 8'hA5, 4'b0000, 4'b1111, 4'b0101, "R9 data write unarmed");
    peek(2'd3, 8'hA5, "R9 data readback");

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule